// File: doc/BRIEF.md
# AES Key Schedule Assist Unit

This unit performs a single assist step of the AES key schedule. A request carries a 128-bit block, an 8-bit round constant, a mode select, a 4-bit reserved selector and the current image of a wider destination register. The block is treated as four 32-bit words. Only the two odd words (bits 63:32 and 127:96) are used. Each one is passed through the forward AES S-box byte by byte. The substituted word is written out as it is, and also rotated by one byte and XORed with the round constant. Software combines these terms with the previous round key to finish the expansion.

The 128-bit result is merged into the destination image under one of two modes. In keep-upper mode, the bits above 127 are passed through. In zero-upper mode, they are cleared. In zero-upper mode, the reserved selector must be all ones. If it is not, the response is flagged as illegal and the destination image is returned untouched. Six status flag bits are reported as zero with every response.

Requests and responses use valid/ready handshakes. The result is registered, so a response appears one cycle after acceptance and is held until it is taken.

Top module: `kga_unit`

## Requirements
- R1: Result bits [31:0] equal SubWord of the source word at bits [63:32]. SubWord applies the forward AES S-box to each of the four bytes independently.
- R2: Result bits [63:32] equal RotWord(SubWord(src[63:32])) XOR {24'h0, imm}. RotWord of w is {w[7:0], w[31:8]}.
- R3: Result bits [95:64] equal SubWord(src[127:96]), and result bits [127:96] equal RotWord(SubWord(src[127:96])) XOR {24'h0, imm}.
- R4: Source bits [31:0] and [95:64] have no effect on any response field.
- R5: With req_zero_upper=0, response bits above 127 equal bits above 127 of req_dest_old as captured at acceptance, and rsp_illegal is 0.
- R6: With req_zero_upper=1 and req_rsvd=4'b1111, response bits above 127 are zero and rsp_illegal is 0.
- R7: With req_zero_upper=1 and req_rsvd other than 4'b1111, rsp_illegal is 1 and rsp_dest equals the whole of req_dest_old as captured at acceptance.
- R8: rsp_flags is 6'b0 whenever rsp_valid is 1.
- R9: A request accepted on a clock edge gives rsp_valid=1 after that edge. A response that is not taken keeps rsp_valid and all response fields stable.
- R10: req_ready is 1 exactly when no response is pending or rsp_ready is 1.
- R11: While rst is high, and in the first cycle after it falls, rsp_valid is 0.
- R12: Source word [127:96] = 32'h3C4FCF09 with imm = 8'h01 gives result bits [127:96] = 32'h01EB848B. This is the first-round AES-128 term for the standard test key, in byte-reversed register order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_src | input | 128 | Source block |
| req_imm | input | 8 | Round constant |
| req_zero_upper | input | 1 | 1 clears destination bits above 127 |
| req_rsvd | input | 4 | Reserved selector, must be all ones in zero-upper mode |
| req_dest_old | input | DEST_W | Current destination image |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_dest | output | DEST_W | New destination image |
| rsp_illegal | output | 1 | Reserved selector violation |
| rsp_flags | output | 6 | Status flags, always zero |

## Verification
The embedded properties check the handshake on every cycle: quiet after reset, a response one cycle after acceptance, and a response held stable under back-pressure. For each accepted request they also check how the upper destination bits are treated in each mode and in the illegal case. The S-box arithmetic, the rotate direction, the position of the round constant and the independence from the even words can only be shown by the bench. Its reference model computes the substitution from logarithm tables and compares every field on every clock, under directed and random traffic with random back-pressure, including the known first-round test vector.

// File: rtl/kga_pkg.sv
package kga_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 32;
    localparam int BLK_W   = 128;
    localparam int N_WORDS = BLK_W / WORD_W;
    localparam int N_BYTES = WORD_W / BYTE_W;
    localparam int N_LANES = N_WORDS / 2;
    localparam int RSV_W   = 4;
    localparam int N_FLAGS = 6;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BLK_W-1:0]  blk_t;

    // Pair of words produced by one lane.
    typedef struct packed {
        word_t rot_x;   // rotated, constant folded in
        word_t sub;     // plain substitution
    } lane_out_t;

    // Multiply in GF(2^8) modulo x^8+x^4+x^3+x+1.
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t aa;
        acc = '0;
        aa  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = aa[7] ? ({aa[6:0], 1'b0} ^ 8'h1B) : {aa[6:0], 1'b0};
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254 (0 maps to 0).
    function automatic byte_t gf_inv(input byte_t a);
        byte_t p;
        byte_t r;
        p = a;
        r = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    // Forward S-box: inverse followed by the affine map.
    function automatic byte_t sbox_fwd(input byte_t a);
        byte_t q;
        byte_t s;
        q = gf_inv(a);
        for (int i = 0; i < BYTE_W; i++) begin
            s[i] = q[i] ^ q[(i + 4) % 8] ^ q[(i + 5) % 8]
                 ^ q[(i + 6) % 8] ^ q[(i + 7) % 8];
        end
        return s ^ 8'h63;
    endfunction

endpackage

// File: rtl/kga_sbox.sv
module kga_sbox
    import kga_pkg::*;
(
    input  byte_t in_b,
    output byte_t out_b
);
    assign out_b = sbox_fwd(in_b);
endmodule

// File: rtl/kga_lane.sv
module kga_lane
    import kga_pkg::*;
(
    input  word_t     src_w,
    input  byte_t     rc,
    output lane_out_t res
);
    word_t sub_w;

    genvar g;
    generate
        for (g = 0; g < N_BYTES; g++) begin : g_byte
            kga_sbox sbox_i (
                .in_b  (src_w[g*BYTE_W +: BYTE_W]),
                .out_b (sub_w[g*BYTE_W +: BYTE_W])
            );
        end
    endgenerate

    always_comb begin
        res.sub   = sub_w;
        res.rot_x = {sub_w[BYTE_W-1:0], sub_w[WORD_W-1:BYTE_W]}
                  ^ {{(WORD_W-BYTE_W){1'b0}}, rc};
    end
endmodule

// File: rtl/kga_merge.sv
module kga_merge
    import kga_pkg::*;
#(
    parameter int DEST_W = 256
) (
    input  blk_t              res,
    input  logic [DEST_W-1:0] old_img,
    input  logic              zero_upper,
    input  logic [RSV_W-1:0]  rsvd,
    output logic [DEST_W-1:0] new_img,
    output logic              illegal
);
    localparam int UP_W = DEST_W - BLK_W;

    logic [UP_W-1:0] upper;

    always_comb begin
        illegal = zero_upper && (rsvd != {RSV_W{1'b1}});
        upper   = zero_upper ? '0 : old_img[DEST_W-1:BLK_W];
        new_img = illegal ? old_img : {upper, res};
    end
endmodule

// File: rtl/kga_unit.sv
module kga_unit
    import kga_pkg::*;
#(
    parameter int DEST_W = 256
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [127:0]         req_src,
    input  logic [7:0]           req_imm,
    input  logic                 req_zero_upper,
    input  logic [3:0]           req_rsvd,
    input  logic [DEST_W-1:0]    req_dest_old,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic [DEST_W-1:0]    rsp_dest,
    output logic                 rsp_illegal,
    output logic [5:0]           rsp_flags
);
    blk_t              res_blk;
    lane_out_t         lane_res [N_LANES];
    logic [DEST_W-1:0] merged;
    logic              merged_ill;
    logic              valid_q;
    logic [DEST_W-1:0] dest_q;
    logic              ill_q;
    logic              fire;
    logic              unused_even;

    // Even words do not take part in the computation.
    assign unused_even = ^{req_src[WORD_W-1:0], req_src[3*WORD_W-1:2*WORD_W]};

    genvar l;
    generate
        for (l = 0; l < N_LANES; l++) begin : g_lane
            kga_lane lane_i (
                .src_w (req_src[(2*l+1)*WORD_W +: WORD_W]),
                .rc    (req_imm),
                .res   (lane_res[l])
            );
            assign res_blk[2*l*WORD_W     +: WORD_W] = lane_res[l].sub;
            assign res_blk[(2*l+1)*WORD_W +: WORD_W] = lane_res[l].rot_x;
        end
    endgenerate

    kga_merge #(.DEST_W(DEST_W)) merge_i (
        .res        (res_blk),
        .old_img    (req_dest_old),
        .zero_upper (req_zero_upper),
        .rsvd       (req_rsvd),
        .new_img    (merged),
        .illegal    (merged_ill)
    );

    assign req_ready = !valid_q || rsp_ready;
    assign fire      = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            dest_q  <= '0;
            ill_q   <= 1'b0;
        end else begin
            if (req_ready) valid_q <= req_valid;
            if (fire) begin
                dest_q <= merged;
                ill_q  <= merged_ill;
            end
        end
    end

    assign rsp_valid   = valid_q;
    assign rsp_dest    = dest_q;
    assign rsp_illegal = ill_q;
    assign rsp_flags   = '0;

    // Assertions

    p_quiet_after_reset_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_valid);

    p_accept_to_resp_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    p_hold_stalled_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_dest) && $stable(rsp_illegal)));

    p_keep_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_zero_upper) |=>
            (!rsp_illegal &&
             rsp_dest[DEST_W-1:BLK_W] == $past(req_dest_old[DEST_W-1:BLK_W])));

    p_zero_upper_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_zero_upper && req_rsvd == 4'hF) |=>
            (!rsp_illegal && rsp_dest[DEST_W-1:BLK_W] == '0));

    p_illegal_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_zero_upper && req_rsvd != 4'hF) |=>
            (rsp_illegal && rsp_dest == $past(req_dest_old)));

endmodule

// File: tb/kga_unit_tb.sv
`timescale 1ns/1ps
module kga_unit_tb_top;
    localparam int DW = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [127:0]  req_src = '0;
    logic [7:0]    req_imm = '0;
    logic          req_zero_upper = 1'b0;
    logic [3:0]    req_rsvd = 4'hF;
    logic [DW-1:0] req_dest_old = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b0;
    logic [DW-1:0] rsp_dest;
    logic          rsp_illegal;
    logic [5:0]    rsp_flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    kga_unit #(.DEST_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_imm(req_imm),
        .req_zero_upper(req_zero_upper), .req_rsvd(req_rsvd),
        .req_dest_old(req_dest_old),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_dest(rsp_dest), .rsp_illegal(rsp_illegal), .rsp_flags(rsp_flags)
    );

    // Reference S-box from exponent/logarithm tables over generator 3.
    int exp_t [256];
    int log_t [256];
    initial begin
        int x;
        x = 1;
        for (int i = 0; i < 255; i++) begin
            exp_t[i] = x;
            log_t[x] = i;
            x = x ^ (((x << 1) ^ ((x & 8'h80) ? 8'h1B : 0)) & 8'hFF);
        end
        exp_t[255] = 1;
        log_t[0]   = 0;
    end

    function automatic int ref_sbox(input int a);
        int v;
        int r;
        v = (a == 0) ? 0 : exp_t[(255 - log_t[a]) % 255];
        r = v;
        for (int k = 1; k <= 4; k++)
            r = r ^ (((v << k) | (v >> (8 - k))) & 8'hFF);
        return r ^ 8'h63;
    endfunction

    function automatic logic [31:0] ref_subword(input logic [31:0] w);
        logic [31:0] o;
        for (int k = 0; k < 4; k++)
            o[k*8 +: 8] = 8'(ref_sbox(int'(w[k*8 +: 8])));
        return o;
    endfunction

    function automatic logic [127:0] ref_block(input logic [127:0] s, input logic [7:0] imm);
        logic [31:0] a;
        logic [31:0] b;
        a = ref_subword(s[63:32]);
        b = ref_subword(s[127:96]);
        return {((b >> 8) | (b << 24)) ^ 32'(imm), b,
                ((a >> 8) | (a << 24)) ^ 32'(imm), a};
    endfunction

    // Model state
    bit          m_valid = 0;
    logic [DW-1:0] m_dest = '0;
    bit          m_ill = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, predict, compare at next negedge.
    task automatic step(input bit v, input logic [127:0] s, input logic [7:0] imm,
                        input bit zu, input logic [3:0] rs,
                        input logic [DW-1:0] old, input bit rdy);
        bit acc;
        bit drn;
        bit n_valid;
        logic [DW-1:0] n_dest;
        bit n_ill;
        logic [127:0] blk;
        req_valid = v; req_src = s; req_imm = imm; req_zero_upper = zu;
        req_rsvd = rs; req_dest_old = old; rsp_ready = rdy;
        #1;
        chk(req_ready == (!m_valid || rdy), "R10", "req_ready",
            DW'(req_ready), DW'(!m_valid || rdy));
        acc = v && (!m_valid || rdy);
        drn = m_valid && rdy;
        n_valid = acc || (m_valid && !drn);
        n_dest = m_dest;
        n_ill  = m_ill;
        if (acc) begin
            blk = ref_block(s, imm);
            n_ill = zu && (rs != 4'hF);
            if (n_ill)   n_dest = old;
            else if (zu) n_dest = {{(DW-128){1'b0}}, blk};
            else         n_dest = {old[DW-1:128], blk};
        end
        @(negedge clk);
        m_valid = n_valid; m_dest = n_dest; m_ill = n_ill;
        chk(rsp_valid == m_valid, "R9", "rsp_valid", DW'(rsp_valid), DW'(m_valid));
        if (m_valid) begin
            chk(rsp_dest[31:0] == m_dest[31:0], "R1", "word0",
                DW'(rsp_dest[31:0]), DW'(m_dest[31:0]));
            chk(rsp_dest[63:32] == m_dest[63:32], "R2", "word1",
                DW'(rsp_dest[63:32]), DW'(m_dest[63:32]));
            chk(rsp_dest[127:64] == m_dest[127:64], "R3", "words2-3",
                DW'(rsp_dest[127:64]), DW'(m_dest[127:64]));
            chk(rsp_dest[DW-1:128] == m_dest[DW-1:128], m_ill ? "R7" : "R5/R6", "upper",
                DW'(rsp_dest[DW-1:128]), DW'(m_dest[DW-1:128]));
            chk(rsp_illegal == m_ill, "R7", "illegal",
                DW'(rsp_illegal), DW'(m_ill));
            chk(rsp_flags == 6'b0, "R8", "flags", DW'(rsp_flags), '0);
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [DW-1:0] rnd_dw();
        logic [DW-1:0] r;
        for (int k = 0; k < DW/32; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    initial begin
        logic [DW-1:0] old_a;
        logic [127:0]  s1;
        logic [DW-1:0] keep;
        old_a = rnd_dw();

        // R11: quiet in reset and the first cycle after it
        repeat (3) begin
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R11", "valid in reset", DW'(rsp_valid), '0);
        end
        rst = 1'b0;
        step(0, '0, 8'h00, 0, 4'hF, '0, 1);
        chk(rsp_valid == 1'b0, "R11", "valid after reset", DW'(rsp_valid), '0);

        // R1/R2: all-zero source gives 63636363 in both low words
        step(1, '0, 8'h00, 0, 4'hF, old_a, 1);
        chk(rsp_dest[63:0] == 64'h6363636363636363, "R1", "zero source",
            DW'(rsp_dest[63:0]), DW'(64'h6363636363636363));

        // R12: known first-round vector, zero-upper legal (R6)
        step(1, {32'h3C4FCF09, 96'h0}, 8'h01, 1, 4'hF, old_a, 1);
        chk(rsp_dest[127:96] == 32'h01EB848B, "R12", "known vector",
            DW'(rsp_dest[127:96]), DW'(32'h01EB848B));
        chk(rsp_dest[DW-1:128] == '0, "R6", "upper cleared",
            DW'(rsp_dest[DW-1:128]), '0);

        // R7: illegal reserved selector leaves destination untouched
        step(1, rnd128(), 8'h36, 1, 4'h0, old_a, 1);
        chk(rsp_illegal && rsp_dest == old_a, "R7", "illegal image",
            rsp_dest, old_a);
        step(1, rnd128(), 8'h1B, 1, 4'hE, old_a, 1);

        // R4: differing even words give the same result
        s1 = rnd128();
        step(1, s1, 8'h80, 0, 4'h3, old_a, 1);
        keep = rsp_dest;
        step(1, {s1[127:96], ~s1[95:64], s1[63:32], ~s1[31:0]}, 8'h80, 0, 4'h3, old_a, 1);
        chk(rsp_dest == keep, "R4", "even words ignored", rsp_dest, keep);

        // R9/R10: back-pressure, response held while new request waits
        step(1, rnd128(), 8'h02, 0, 4'hF, rnd_dw(), 0);
        keep = rsp_dest;
        step(1, rnd128(), 8'h04, 1, 4'hF, rnd_dw(), 0);
        step(1, rnd128(), 8'h08, 0, 4'hF, rnd_dw(), 0);
        chk(rsp_dest == keep, "R9", "held response", rsp_dest, keep);
        step(1, rnd128(), 8'h10, 0, 4'hF, rnd_dw(), 1);
        step(0, '0, 8'h00, 0, 4'hF, '0, 1);

        // Random traffic with random back-pressure
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4) != 0, rnd128(), 8'($urandom), $urandom % 2,
                 (($urandom % 3) == 0) ? 4'($urandom) : 4'hF, rnd_dw(),
                 ($urandom % 3) != 0);
        end
        step(0, '0, 8'h00, 0, 4'hF, '0, 1);
        step(0, '0, 8'h00, 0, 4'hF, '0, 1);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule